// File: doc/BRIEF.md
# Single-Cycle Main and ALU Control Decoder

This block turns the fields of one fetched instruction into the full set of control lines for a single-cycle load/store datapath. From the 6-bit major opcode it derives the path selects and the enables for memory access, register write-back, branching and jumping. It also derives a 2-bit ALU class. From that class, and for register-register instructions from the 6-bit function field, it derives a 4-bit ALU operation code. It also picks which 5-bit register field names the write-back destination.

The decoder is purely combinational and holds no state. The surrounding datapath presents the opcode, the two register-number fields and the function field, and uses every output in the same cycle. The supported set is register-register add, subtract, and, or and set-on-less-than, plus word load, word store, branch-on-equal, immediate add and unconditional jump. Immediate add shares the address-add path that loads and stores use.

Top module: `ctrl_decoder`

## Requirements
- R1: For opcode 000000 (register-register), reg_dst=1, reg_wr=1, alu_op=10, alu_src=0, mem_rd=0, mem_wr=0, mem_to_reg=0, branch=0 and jump=0, provided the function code is supported.
- R2: With alu_op=10, the function codes map to alu_ctl as follows: 100000 (add) gives 0010, 100010 (subtract) gives 0110, 100100 (and) gives 0000, 100101 (or) gives 0001, and 101010 (set-on-less-than) gives 0111.
- R3: A register-register instruction with any other function code gives alu_ctl=1111 and reg_wr=0. All other outputs stay as in R1.
- R4: For opcode 100011 (load word), alu_src=1, mem_rd=1, mem_to_reg=1, reg_wr=1, alu_op=00, and reg_dst, mem_wr, branch and jump are 0.
- R5: For opcode 101011 (store word), alu_src=1, mem_wr=1, alu_op=00, and reg_wr, mem_rd, mem_to_reg, reg_dst, branch and jump are 0.
- R6: For opcode 000100 (branch-on-equal), branch=1, alu_op=01, alu_ctl=0110, and alu_src, mem_rd, mem_wr, reg_wr and jump are 0. The don't-care selects reg_dst and mem_to_reg are driven to 0.
- R7: For opcode 001000 (immediate add), alu_src=1, alu_op=00, alu_ctl=0010, reg_wr=1, and reg_dst, mem_to_reg, mem_rd, mem_wr, branch and jump are 0.
- R8: For opcode 000010 (jump), jump=1, and reg_wr, mem_rd, mem_wr and branch are 0. Every select is 0 and alu_op=00.
- R9: Any opcode not listed in R1 and R4 to R8 drives all eight single-bit controls to 0 and alu_op to 00.
- R10: wr_reg equals the rd field (instruction bits 15:11) when reg_dst=1 and the rt field (instruction bits 20:16) when reg_dst=0.
- R11: alu_op=00 always gives alu_ctl=0010 (add), and alu_op=01 always gives alu_ctl=0110 (subtract).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| rt | input | 5 | Second register field, instruction bits 20:16 |
| rd | input | 5 | Third register field, instruction bits 15:11 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| jump | output | 1 | Take the absolute jump target |
| branch | output | 1 | Instruction is a conditional branch |
| reg_dst | output | 1 | 1 selects rd, 0 selects rt as destination |
| alu_src | output | 1 | 1 selects the sign-extended immediate as ALU operand B |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | 1 writes back memory data, 0 the ALU result |
| reg_wr | output | 1 | Register file write enable |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 by function code |
| alu_ctl | output | 4 | ALU operation code |
| wr_reg | output | 5 | Selected destination register number |

## Verification
The bench sweeps every one of the 64 opcodes. A decoder that left a stray enable on for an unlisted opcode would corrupt registers or memory on reserved encodings. The sweep would catch that, and it would also catch a mistyped opcode constant, which would silently send a real instruction down the unsupported path. An unknown function code under the register-register opcode is exercised on its own. Getting it wrong would either write a garbage result or reuse the previous operation code. Destination selection is probed with the rt and rd fields set to 0 and 31 in both orders. Swapped fields or a mux keyed on the wrong select would then show a visibly wrong register number. Branch-on-equal is checked for its don't-care selects being held low.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int REG_W   = 5;
    localparam int AOP_W   = 2;
    localparam int ACTL_W  = 4;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_RSVD  = 2'b11
    } alu_class_t;

    localparam logic [ACTL_W-1:0] ACTL_AND = 4'b0000;
    localparam logic [ACTL_W-1:0] ACTL_OR  = 4'b0001;
    localparam logic [ACTL_W-1:0] ACTL_ADD = 4'b0010;
    localparam logic [ACTL_W-1:0] ACTL_SUB = 4'b0110;
    localparam logic [ACTL_W-1:0] ACTL_SLT = 4'b0111;
    localparam logic [ACTL_W-1:0] ACTL_BAD = 4'b1111;

    typedef struct packed {
        logic       jump;
        logic       branch;
        logic       reg_dst;
        logic       alu_src;
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_to_reg;
        logic       reg_wr;
        alu_class_t alu_op;
    } ctrl_t;

    // Build a control word, listing every field so no entry leaves one out.
    function automatic ctrl_t mk_ctrl(
        input logic j, input logic b, input logic rdst, input logic asrc,
        input logic mrd, input logic mwr, input logic m2r, input logic rwr,
        input alu_class_t aop);
        ctrl_t c;
        c.jump       = j;
        c.branch     = b;
        c.reg_dst    = rdst;
        c.alu_src    = asrc;
        c.mem_rd     = mrd;
        c.mem_wr     = mwr;
        c.mem_to_reg = m2r;
        c.reg_wr     = rwr;
        c.alu_op     = aop;
        return c;
    endfunction

endpackage

// File: rtl/main_decoder.sv
module main_decoder
    import ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: ctrl = mk_ctrl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AOP_FUNCT);
            OPC_LOAD:  ctrl = mk_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AOP_ADD);
            OPC_STORE: ctrl = mk_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, AOP_ADD);
            OPC_BEQ:   ctrl = mk_ctrl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AOP_SUB);
            OPC_ADDI:  ctrl = mk_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, AOP_ADD);
            OPC_JUMP:  ctrl = mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AOP_ADD);
            default:   ctrl = mk_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AOP_ADD);
        endcase
    end
endmodule

// File: rtl/alu_decoder.sv
module alu_decoder
    import ctrl_pkg::*;
(
    input  alu_class_t        alu_op,
    input  logic [FN_W-1:0]   funct,
    output logic [ACTL_W-1:0] alu_ctl,
    output logic              op_ok
);
    always_comb begin
        op_ok = 1'b1;
        unique case (alu_op)
            AOP_ADD: alu_ctl = ACTL_ADD;
            AOP_SUB: alu_ctl = ACTL_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  alu_ctl = ACTL_ADD;
                    FN_SUB:  alu_ctl = ACTL_SUB;
                    FN_AND:  alu_ctl = ACTL_AND;
                    FN_OR:   alu_ctl = ACTL_OR;
                    FN_SLT:  alu_ctl = ACTL_SLT;
                    default: begin
                        alu_ctl = ACTL_BAD;
                        op_ok   = 1'b0;
                    end
                endcase
            end
            default: begin
                alu_ctl = ACTL_BAD;
                op_ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wreg_select.sv
module wreg_select
    import ctrl_pkg::*;
(
    input  logic             use_rd,
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] rd,
    output logic [REG_W-1:0] wr_reg
);
    always_comb wr_reg = use_rd ? rd : rt;
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
    import ctrl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] rt,
    input  logic [4:0] rd,
    input  logic [5:0] funct,
    output logic       jump,
    output logic       branch,
    output logic       reg_dst,
    output logic       alu_src,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       mem_to_reg,
    output logic       reg_wr,
    output logic [1:0] alu_op,
    output logic [3:0] alu_ctl,
    output logic [4:0] wr_reg
);
    ctrl_t base;
    logic  op_ok;

    main_decoder u_main (
        .opcode (opcode),
        .ctrl   (base)
    );

    alu_decoder u_alu (
        .alu_op  (base.alu_op),
        .funct   (funct),
        .alu_ctl (alu_ctl),
        .op_ok   (op_ok)
    );

    wreg_select u_wsel (
        .use_rd (base.reg_dst),
        .rt     (rt),
        .rd     (rd),
        .wr_reg (wr_reg)
    );

    always_comb begin
        jump       = base.jump;
        branch     = base.branch;
        reg_dst    = base.reg_dst;
        alu_src    = base.alu_src;
        mem_rd     = base.mem_rd;
        mem_wr     = base.mem_wr;
        mem_to_reg = base.mem_to_reg;
        // Unknown operation code blocks write-back (R3).
        reg_wr     = base.reg_wr & op_ok;
        alu_op     = base.alu_op;
    end
endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
    input logic [5:0] opcode,
    input logic [4:0] rt,
    input logic [4:0] rd,
    input logic [5:0] funct,
    input logic       jump,
    input logic       branch,
    input logic       reg_dst,
    input logic       alu_src,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mem_to_reg,
    input logic       reg_wr,
    input logic [1:0] alu_op,
    input logic [3:0] alu_ctl,
    input logic [4:0] wr_reg
);
    logic known;
    always_comb known = !$isunknown({opcode, rt, rd, funct});

    always_comb begin
        if (known) begin
            AST_MEM_EXCL: assert (!(mem_rd && mem_wr)) else $error("mem rd/wr both set"); // R9
            AST_STORE_NOWB: assert (!mem_wr || !reg_wr) else $error("store writes reg"); // R5
            AST_LOAD_WB: assert (!mem_to_reg || (mem_rd && reg_wr)) else $error("load path"); // R4
            AST_FLOW_EXCL: assert (!(jump && branch)) else $error("jump and branch"); // R8
            AST_BR_SUB: assert (!branch || alu_ctl == 4'b0110) else $error("branch op"); // R6
            AST_ADD_CLASS: assert (alu_op != 2'b00 || alu_ctl == 4'b0010) else $error("add class"); // R11
            AST_DEST_RD: assert (!reg_dst || wr_reg == rd) else $error("dest rd"); // R10
            AST_DEST_RT: assert (reg_dst || wr_reg == rt) else $error("dest rt"); // R10
            AST_BAD_FN: assert (alu_ctl != 4'b1111 || !reg_wr) else $error("bad fn writes"); // R3
        end
    end
endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
    .opcode(opcode), .rt(rt), .rd(rd), .funct(funct),
    .jump(jump), .branch(branch), .reg_dst(reg_dst), .alu_src(alu_src),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
    .alu_op(alu_op), .alu_ctl(alu_ctl), .wr_reg(wr_reg)
);

// File: tb/sim_ctrl_decoder.sv
module sim_ctrl_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [5:0] opcode = '0;
    logic [4:0] rt = '0, rd = '0;
    logic [5:0] funct = '0;
    logic jump, branch, reg_dst, alu_src, mem_rd, mem_wr, mem_to_reg, reg_wr;
    logic [1:0] alu_op;
    logic [3:0] alu_ctl;
    logic [4:0] wr_reg;

    ctrl_decoder u0 (
        .opcode(opcode), .rt(rt), .rd(rd), .funct(funct),
        .jump(jump), .branch(branch), .reg_dst(reg_dst), .alu_src(alu_src),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
        .alu_op(alu_op), .alu_ctl(alu_ctl), .wr_reg(wr_reg)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Vector: req(4) opcode(6) rt(5) rd(5) funct(6) | j b rdst asrc mrd mwr m2r rwr aop(2) actl(4) wreg(5)
    localparam int NV = 14;
    localparam logic [44:0] VEC [NV] = '{
        {4'd1,  6'b000000, 5'd9,  5'd17, 6'b100000, 8'b00100001, 2'b10, 4'b0010, 5'd17}, // R1 R2 add
        {4'd2,  6'b000000, 5'd9,  5'd17, 6'b100010, 8'b00100001, 2'b10, 4'b0110, 5'd17}, // R2 sub
        {4'd2,  6'b000000, 5'd9,  5'd17, 6'b100100, 8'b00100001, 2'b10, 4'b0000, 5'd17}, // R2 and
        {4'd2,  6'b000000, 5'd9,  5'd17, 6'b100101, 8'b00100001, 2'b10, 4'b0001, 5'd17}, // R2 or
        {4'd2,  6'b000000, 5'd9,  5'd17, 6'b101010, 8'b00100001, 2'b10, 4'b0111, 5'd17}, // R2 slt
        {4'd3,  6'b000000, 5'd9,  5'd17, 6'b000111, 8'b00100000, 2'b10, 4'b1111, 5'd17}, // R3
        {4'd4,  6'b100011, 5'd9,  5'd17, 6'b100000, 8'b00011011, 2'b00, 4'b0010, 5'd9},  // R4
        {4'd5,  6'b101011, 5'd9,  5'd17, 6'b100000, 8'b00010100, 2'b00, 4'b0010, 5'd9},  // R5
        {4'd6,  6'b000100, 5'd9,  5'd17, 6'b100000, 8'b01000000, 2'b01, 4'b0110, 5'd9},  // R6
        {4'd7,  6'b001000, 5'd9,  5'd17, 6'b100010, 8'b00010001, 2'b00, 4'b0010, 5'd9},  // R7
        {4'd8,  6'b000010, 5'd9,  5'd17, 6'b100000, 8'b10000000, 2'b00, 4'b0010, 5'd9},  // R8
        {4'd9,  6'b001101, 5'd9,  5'd17, 6'b100000, 8'b00000000, 2'b00, 4'b0010, 5'd9},  // R9
        {4'd10, 6'b000000, 5'd31, 5'd0,  6'b100000, 8'b00100001, 2'b10, 4'b0010, 5'd0},  // R10 rd
        {4'd10, 6'b001000, 5'd0,  5'd31, 6'b100000, 8'b00010001, 2'b00, 4'b0010, 5'd0}   // R10 rt
    };

    function automatic logic [18:0] outs();
        return {jump, branch, reg_dst, alu_src, mem_rd, mem_wr, mem_to_reg, reg_wr,
                alu_op, alu_ctl, wr_reg};
    endfunction

    task automatic check(input int req, input logic [18:0] got, input logic [18:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d op=%b fn=%b got=%b expected=%b", req, opcode, funct, got, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [4:0] t, input logic [4:0] d,
                         input logic [5:0] fn);
        @(posedge clk);
        opcode = op; rt = t; rd = d; funct = fn;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time state: all-zero instruction is register-register with an
        // unknown function code (R3): no write, code 1111, destination rd.
        apply(6'd0, 5'd0, 5'd0, 6'd0);
        check(3, outs(), {8'b00100000, 2'b10, 4'b1111, 5'd0});

        foreach (VEC[i])
            begin
                apply(VEC[i][40:35], VEC[i][34:30], VEC[i][29:25], VEC[i][24:19]);
                check(int'(VEC[i][44:41]), outs(), VEC[i][18:0]);
            end

        // R9 sweep of every opcode not in the supported set.
        for (int op = 0; op < 64; op++) begin
            if (!(op inside {6'b000000, 6'b000010, 6'b000100, 6'b001000, 6'b100011, 6'b101011})) begin
                apply(6'(op), 5'd6, 5'd21, 6'b101010);
                check(9, outs(), {8'b00000000, 2'b00, 4'b0010, 5'd6});
            end
        end

        // R11: add class and subtract class codes independent of funct.
        apply(6'b100011, 5'd2, 5'd3, 6'b100100);
        check(11, {15'd0, alu_ctl}, {15'd0, 4'b0010});
        apply(6'b000100, 5'd2, 5'd3, 6'b100101);
        check(11, {15'd0, alu_ctl}, {15'd0, 4'b0110});

        // R3: another unknown funct right after a valid one; no leftover code.
        apply(6'b000000, 5'd4, 5'd12, 6'b101010);
        apply(6'b000000, 5'd4, 5'd12, 6'b111111);
        check(3, outs(), {8'b00100000, 2'b10, 4'b1111, 5'd12});

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule